// File: doc/BRIEF.md
# Bridge Fault Diagnostic Controller

This block watches the fault comparators of a two-winding bridge driver and decides how the bridge reacts. A drop comparator sits across each conducting high-side and low-side switch. Each phase also has a comparator that reports a current below 35 % of full scale. The controller latches short circuits per phase, checks for an open winding while the translator rests at Home, and folds the supply and temperature monitors into one severity-ranked code. That code drives two active-low flag pins.

The power stage supplies one strobe, `sample_i`, at the end of blanking plus the settle delay of each on phase. It also supplies the translator step event and a Home indicator. The controller's outputs go to the gate logic, which disables a phase or forces safety mode, and to the translator, which it can send back to Home. Status inputs are registered, so each reaction appears one clock after its cause.

Top module: `bridge_fault_diag`

## Requirements
- R1: After reset, both flags are high, no phase is disabled, and `safe_o` and `xlat_rst_o` are low.
- R2: A drop comparator input on phase p is sampled only in a cycle with `sample_i` high. Either the high-side or the low-side drop then sets `ph_off_o[p]` from the next clock. A drop with no strobe has no effect.
- R3: A latched short is cleared by the next `step_i`, and the phase is driven again. A short is re-detected at a later strobe. When step and strobe coincide, the step wins.
- R4: A short on one phase leaves the other phase's disable output unchanged.
- R5: An open load is detected when `sample_i`, `home_i` and `low_cur_i[p]` are all high. It is reported only from the clock after the following `step_i`.
- R6: A reported open load does not disable any phase. It stays flagged until `home_i` rises again, and is cleared on that clock.
- R7: While `ov_i` is high, `safe_o` is high one clock later and the flags read 00.
- R8: While `vreg_uv_i` or `vdd_uv_i` is high, one clock later both phases are disabled, `xlat_rst_o` is high and the flags read 00. All latched short and open state is discarded.
- R9: `ot_set_i` disables both phases and sets flags 00 from the next clock. The condition holds until `ot_clr_i` is seen, with set winning if both are high.
- R10: Flag code {ff2_n_o, ff1_n_o}: 11 = no fault, 10 = short, 01 = open load, 00 = supply or thermal. A supply or thermal fault outranks a short, and a short outranks an open load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_i | input | 1 | Fault sample strobe (after blank plus delay) |
| step_i | input | 1 | Translator step event |
| home_i | input | 1 | Translator is at Home position |
| hs_drop_i | input | NPH | Excess drop across high-side switch, per phase |
| ls_drop_i | input | NPH | Excess drop across low-side switch, per phase |
| low_cur_i | input | NPH | Phase current below 35 % of full scale |
| ov_i | input | 1 | Load supply overvoltage |
| vreg_uv_i | input | 1 | Gate regulator undervoltage |
| vdd_uv_i | input | 1 | Logic supply undervoltage |
| ot_set_i | input | 1 | Over-temperature set threshold |
| ot_clr_i | input | 1 | Over-temperature clear threshold |
| ph_off_o | output | NPH | Disable all switches of phase |
| safe_o | output | 1 | Safety mode: low sides on, high sides off |
| xlat_rst_o | output | 1 | Request translator reset to Home |
| ff1_n_o | output | 1 | Fault flag, low bit, active low |
| ff2_n_o | output | 1 | Fault flag, high bit, active low |

## Verification
The bench drives a drop with no strobe, and a strobe together with a step, to separate a design that samples continuously or lets the strobe beat the step. The first would latch shorts from switching transients. The second would keep a shorted phase off forever. It checks that an open winding found at Home stays silent until the step, then survives later steps and a short until Home returns. A design that flags early, clears on any step, or lets the open state disable the bridge fails here. Undervoltage with shorts and open detections pending shows whether that state is really discarded, and overvoltage on top of a short checks the ranking of the codes.

// File: rtl/bridge_fault_diag.sv
module bridge_fault_diag #(
  parameter int NPH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sample_i,
  input  logic           step_i,
  input  logic           home_i,
  input  logic [NPH-1:0] hs_drop_i,
  input  logic [NPH-1:0] ls_drop_i,
  input  logic [NPH-1:0] low_cur_i,
  input  logic           ov_i,
  input  logic           vreg_uv_i,
  input  logic           vdd_uv_i,
  input  logic           ot_set_i,
  input  logic           ot_clr_i,
  output logic [NPH-1:0] ph_off_o,
  output logic           safe_o,
  output logic           xlat_rst_o,
  output logic           ff1_n_o,
  output logic           ff2_n_o
);

  logic [NPH-1:0] short_q, open_pend_q;
  logic           open_q, ov_q, uv_q, ot_q, home_q;
  logic           sys_flt, any_short;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ov_q   <= 1'b0;
      uv_q   <= 1'b0;
      ot_q   <= 1'b0;
      home_q <= 1'b0;
    end else begin
      ov_q   <= ov_i;
      uv_q   <= vreg_uv_i | vdd_uv_i;
      home_q <= home_i;
      if (ot_set_i)      ot_q <= 1'b1;
      else if (ot_clr_i) ot_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || uv_q) begin
      short_q     <= '0;
      open_pend_q <= '0;
      open_q      <= 1'b0;
    end else begin
      if (step_i)        short_q <= '0;
      else if (sample_i) short_q <= short_q | hs_drop_i | ls_drop_i;

      if (step_i)
        open_pend_q <= '0;
      else if (sample_i && home_i)
        open_pend_q <= open_pend_q | low_cur_i;

      if (step_i && |open_pend_q) open_q <= 1'b1;
      else if (home_i && !home_q) open_q <= 1'b0;
    end
  end

  assign sys_flt   = ov_q | uv_q | ot_q;
  assign any_short = |short_q;

  assign ph_off_o   = short_q | {NPH{uv_q | ot_q}};
  assign safe_o     = ov_q;
  assign xlat_rst_o = uv_q;
  assign ff2_n_o    = !sys_flt && (any_short || !open_q);
  assign ff1_n_o    = !sys_flt && !any_short;

endmodule

// File: rtl/bridge_fault_diag_chk.sv
module bridge_fault_diag_chk #(
  parameter int NPH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sample_i,
  input logic           step_i,
  input logic           ov_i,
  input logic           vreg_uv_i,
  input logic           vdd_uv_i,
  input logic           ot_set_i,
  input logic [NPH-1:0] short_q,
  input logic [NPH-1:0] ph_off_o,
  input logic           safe_o,
  input logic           xlat_rst_o,
  input logic           ff1_n_o,
  input logic           ff2_n_o
);

  // R2
  no_unstrobed_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sample_i) |-> ((short_q & ~$past(short_q)) == '0));

  // R3
  step_clears_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> (short_q == '0));

  // R7
  ov_safe_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ov_i)) |-> (safe_o && !ff1_n_o && !ff2_n_o));

  // R8
  uv_reset_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ($past(vreg_uv_i) || $past(vdd_uv_i))) |->
      (xlat_rst_o && (&ph_off_o) && !ff1_n_o && !ff2_n_o));

  // R9
  ot_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ot_set_i)) |-> ((&ph_off_o) && !ff1_n_o && !ff2_n_o));

  // R10
  short_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|short_q && ff2_n_o) |-> !ff1_n_o);

endmodule

bind bridge_fault_diag bridge_fault_diag_chk #(.NPH(NPH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .step_i(step_i),
  .ov_i(ov_i), .vreg_uv_i(vreg_uv_i), .vdd_uv_i(vdd_uv_i), .ot_set_i(ot_set_i),
  .short_q(short_q), .ph_off_o(ph_off_o), .safe_o(safe_o),
  .xlat_rst_o(xlat_rst_o), .ff1_n_o(ff1_n_o), .ff2_n_o(ff2_n_o)
);

// File: tb/sim_bridge_fault_diag.sv
module sim_bridge_fault_diag;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sample_i = 0, step_i = 0, home_i = 1;
  logic [1:0] hs_drop_i = 0, ls_drop_i = 0, low_cur_i = 0;
  logic ov_i = 0, vreg_uv_i = 0, vdd_uv_i = 0, ot_set_i = 0, ot_clr_i = 0;
  logic [1:0] ph_off_o;
  logic safe_o, xlat_rst_o, ff1_n_o, ff2_n_o;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  typedef struct { logic [5:0] exp; string tag; } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  bridge_fault_diag #(.NPH(2)) u0 (
    .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .step_i(step_i),
    .home_i(home_i), .hs_drop_i(hs_drop_i), .ls_drop_i(ls_drop_i),
    .low_cur_i(low_cur_i), .ov_i(ov_i), .vreg_uv_i(vreg_uv_i),
    .vdd_uv_i(vdd_uv_i), .ot_set_i(ot_set_i), .ot_clr_i(ot_clr_i),
    .ph_off_o(ph_off_o), .safe_o(safe_o), .xlat_rst_o(xlat_rst_o),
    .ff1_n_o(ff1_n_o), .ff2_n_o(ff2_n_o)
  );

  wire [5:0] obs = {ph_off_o, safe_o, xlat_rst_o, ff2_n_o, ff1_n_o};

  task automatic compare(input logic [5:0] e, input string t);
    n_cmp++;
    if (obs !== e) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", t, obs, e);
    end
  endtask

  // driver: inputs are set at a negedge, expectation is for after the next posedge
  task automatic cyc(input logic [5:0] e, input string t);
    item_t it;
    it.exp = e; it.tag = t;
    sb.push_back(it);
    @(negedge clk);
    sample_i = 0; step_i = 0; ot_set_i = 0; ot_clr_i = 0;
    hs_drop_i = 0; ls_drop_i = 0; low_cur_i = 0;
  endtask

  // monitor
  initial forever begin
    @(posedge clk);
    #2;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      compare(it.exp, it.tag);
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare(6'b000011, "R1 in reset");
    rst_n = 1'b1;
    cyc(6'b000011, "R1 idle after reset");
    ls_drop_i = 2'b01;                         cyc(6'b000011, "R2 drop without strobe ignored");
    sample_i = 1; ls_drop_i = 2'b01;           cyc(6'b010010, "R2 low-side short phase0");
    cyc(6'b010010, "R3 short held until step");
    step_i = 1; home_i = 0;                    cyc(6'b000011, "R3 step re-enables");
    sample_i = 1; hs_drop_i = 2'b10; ls_drop_i = 2'b10; cyc(6'b100010, "R4 shorted load phase1 only");
    sample_i = 1; step_i = 1; hs_drop_i = 2'b10; cyc(6'b000011, "R3 step beats strobe");
    home_i = 1;                                cyc(6'b000011, "R6 home entry idle");
    sample_i = 1; low_cur_i = 2'b01;           cyc(6'b000011, "R5 open not reported before step");
    step_i = 1; home_i = 0;                    cyc(6'b000001, "R5 open reported after step");
    step_i = 1;                                cyc(6'b000001, "R6 open kept across steps, no disable");
    sample_i = 1; ls_drop_i = 2'b01;           cyc(6'b010010, "R10 short outranks open");
    step_i = 1;                                cyc(6'b000001, "R6 open still flagged");
    home_i = 1;                                cyc(6'b000011, "R6 open cleared on home entry");
    ov_i = 1;                                  cyc(6'b001000, "R7 overvoltage safety");
    ov_i = 0;                                  cyc(6'b000011, "R7 overvoltage released");
    ot_set_i = 1;                              cyc(6'b110000, "R9 thermal set");
    cyc(6'b110000, "R9 thermal hysteresis hold");
    ot_set_i = 1; ot_clr_i = 1;                cyc(6'b110000, "R9 set wins over clear");
    ot_clr_i = 1;                              cyc(6'b000011, "R9 thermal cleared");
    sample_i = 1; ls_drop_i = 2'b01; low_cur_i = 2'b10; cyc(6'b010010, "R8 setup short and open");
    vreg_uv_i = 1;                             cyc(6'b110100, "R8 regulator undervoltage");
    vreg_uv_i = 0;                             cyc(6'b000011, "R8 state discarded");
    step_i = 1; home_i = 0;                    cyc(6'b000011, "R8 no stale open report");
    vdd_uv_i = 1;                              cyc(6'b110100, "R8 logic undervoltage");
    vdd_uv_i = 0;                              cyc(6'b000011, "R8 recovered");
    sample_i = 1; hs_drop_i = 2'b01;           cyc(6'b010010, "R2 high-side short phase0");
    ov_i = 1;                                  cyc(6'b011000, "R10 supply outranks short");
    ov_i = 0; step_i = 1;                      cyc(6'b000011, "R10 all clear");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule